// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between an 8-bit CPU with a 64 KB address space and a 128 KB RAM plus a ROM. It decodes the top nibble of the CPU address into four regions: a switchable 16 KB window at the bottom, a fixed RAM area, a 4 KB window for peripheral devices and a top region. It then drives one chip select for the RAM, one for the ROM and one for the device window. It also drives the three upper RAM address lines. Inside the window these lines come from a bank register. Everywhere else they follow the CPU's own two top address bits with the highest line held low.

The bank register holds four bits. A peripheral controller loads it from the data bus with a one-cycle load strobe, after the CPU has written to an address that the controller owns. Only the low three bits choose one of eight 16 KB banks. Because fixed RAM also lives on physical banks 1 and 2, selecting bank 2 makes the lower half of the window alias the top 8 KB of fixed RAM. A mode input decides whether the top region reaches the ROM or is plain writable RAM. Active-low read and write strobes are decoded from the CPU read/write line and the E phase.

Top module: `bmm_mapper`

## Requirements
- R1: When the address nibble is 0x0 to 0x3 (window), `ram_cs_n` is 0 and `ram_ahi` equals bits 2:0 of the bank register.
- R2: When the address nibble is 0x4 to 0x9 (fixed RAM), `ram_cs_n` is 0 and `ram_ahi` is {0, A15, A14}.
- R3: When the address nibble is 0xA (device window), `dev_cs_n` is 0 and both `ram_cs_n` and `rom_cs_n` are 1. At no time is more than one of the three selects low.
- R4: When the address nibble is 0xB to 0xF and `rom_en` is 1, `rom_cs_n` is 0 and `ram_cs_n` is 1, so a write there leaves RAM unchanged. With `rom_en` at 0, `ram_cs_n` is 0 instead, `ram_ahi` is {0, A15, A14}, and the RAM there is writable.
- R5: After reset the bank register reads 0.
- R6: The bank register takes `bank_d` on a rising clock edge at which `bank_ld` is 1. The new value is visible from that edge on. On every other edge it holds its value, whatever `bank_d` is.
- R7: Bit 3 of the bank register is stored and shown on `bank_q`, but it has no effect on `ram_ahi`.
- R8: `rd_n` is 0 exactly when E is 1 and `cpu_rw` is 1 (read). `wr_n` is 0 exactly when E is 1 and `cpu_rw` is 0 (write). The two are never 0 together.
- R9: With bank 2 selected, window offsets 0x0000 to 0x1FFF reach the same RAM cells as CPU addresses 0x8000 to 0x9FFF, so a write through either path can be read through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the bank register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi | input | 4 | CPU address bits 15:12 |
| cpu_rw | input | 1 | CPU read/write line, 1 = read |
| cpu_e | input | 1 | CPU E phase clock |
| bank_d | input | 4 | Low nibble of the data bus, the bank value to load |
| bank_ld | input | 1 | Load strobe from the peripheral controller |
| rom_en | input | 1 | 1 = top region goes to ROM, 0 = RAM-only mode |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| dev_cs_n | output | 1 | Device window select, active low |
| ram_ahi | output | 3 | RAM address bits A16:A14 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bank_q | output | 4 | Current bank register contents |

## Verification
The selects, `ram_ahi` and both strobes are combinational in the inputs and the bank register, so they are due in the same cycle as the inputs that cause them. A bank load becomes visible one edge after the strobe. The bench drives inputs on the falling edge. Its reference model updates the bank on the rising edge, and the comparison runs 2 ns after that rising edge, so the load has landed and the inputs are stable. The aliasing checks use a behavioural RAM in the bench, indexed by the block's own `ram_ahi` outputs. They read back one cycle after the write, which shows the corruption of fixed RAM at the ports.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  localparam int NIB_W  = 4;
  localparam int BANK_W = 4;
  localparam int NBANKS = 8;
  localparam int SEL_W  = $clog2(NBANKS);

  typedef enum logic [1:0] {
    RGN_WIN   = 2'd0,
    RGN_FIXED = 2'd1,
    RGN_DEV   = 2'd2,
    RGN_TOP   = 2'd3
  } rgn_e;

  localparam logic [NIB_W-1:0] FIXED_LO = 4'h4;
  localparam logic [NIB_W-1:0] DEV_LO   = 4'hA;
  localparam logic [NIB_W-1:0] TOP_LO   = 4'hB;

  // region of a CPU address, from its top nibble
  function automatic rgn_e rgn_of(input logic [NIB_W-1:0] nib);
    if (nib < FIXED_LO)    return RGN_WIN;
    else if (nib < DEV_LO) return RGN_FIXED;
    else if (nib < TOP_LO) return RGN_DEV;
    else                   return RGN_TOP;
  endfunction

  // upper RAM address bits: bank inside the window, CPU A15:A14 elsewhere
  function automatic logic [SEL_W-1:0] phys_hi(input rgn_e r,
                                               input logic [NIB_W-1:0] nib,
                                               input logic [SEL_W-1:0] sel);
    if (r == RGN_WIN) return sel;
    return {1'b0, nib[NIB_W-1:NIB_W-2]};
  endfunction
endpackage

// File: rtl/bmm_region_dec.sv
module bmm_region_dec
  import bmm_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic             rom_en,
  output rgn_e             rgn,
  output logic             ram_sel,
  output logic             rom_sel,
  output logic             dev_sel
);
  always_comb begin
    rgn     = rgn_of(nib);
    ram_sel = (rgn == RGN_WIN) || (rgn == RGN_FIXED) ||
              ((rgn == RGN_TOP) && !rom_en);
    rom_sel = (rgn == RGN_TOP) && rom_en;
    dev_sel = (rgn == RGN_DEV);
  end
endmodule

// File: rtl/bmm_bank_reg.sv
module bmm_bank_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/bmm_strobe_gen.sv
module bmm_strobe_gen (
  input  logic cpu_e,
  input  logic cpu_rw,
  output logic rd_n,
  output logic wr_n
);
  // two-to-four decode of {E, R/W}; only the E-high codes drive strobes
  logic [3:0] code_hot;
  always_comb begin
    code_hot = 4'b0000;
    code_hot[{cpu_e, cpu_rw}] = 1'b1;
  end
  assign rd_n = ~code_hot[3];
  assign wr_n = ~code_hot[2];
endmodule

// File: rtl/bmm_mapper.sv
module bmm_mapper
  import bmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  addr_hi,
  input  logic              cpu_rw,
  input  logic              cpu_e,
  input  logic [BANK_W-1:0] bank_d,
  input  logic              bank_ld,
  input  logic              rom_en,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic              dev_cs_n,
  output logic [SEL_W-1:0]  ram_ahi,
  output logic              rd_n,
  output logic              wr_n,
  output logic [BANK_W-1:0] bank_q
);
  rgn_e rgn_w;
  logic ram_sel_w, rom_sel_w, dev_sel_w;

  bmm_region_dec u_dec (
    .nib     (addr_hi),
    .rom_en  (rom_en),
    .rgn     (rgn_w),
    .ram_sel (ram_sel_w),
    .rom_sel (rom_sel_w),
    .dev_sel (dev_sel_w)
  );

  bmm_bank_reg #(.W(BANK_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (bank_ld),
    .d     (bank_d),
    .q     (bank_q)
  );

  bmm_strobe_gen u_strb (
    .cpu_e  (cpu_e),
    .cpu_rw (cpu_rw),
    .rd_n   (rd_n),
    .wr_n   (wr_n)
  );

  assign ram_cs_n = ~ram_sel_w;
  assign rom_cs_n = ~rom_sel_w;
  assign dev_cs_n = ~dev_sel_w;
  assign ram_ahi  = phys_hi(rgn_w, addr_hi, bank_q[SEL_W-1:0]);
endmodule

// File: rtl/bmm_mapper_chk.sv
module bmm_mapper_chk
  import bmm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NIB_W-1:0]  addr_hi,
  input logic              cpu_rw,
  input logic              cpu_e,
  input logic [BANK_W-1:0] bank_d,
  input logic              bank_ld,
  input logic              rom_en,
  input logic              ram_cs_n,
  input logic              rom_cs_n,
  input logic              dev_cs_n,
  input logic [SEL_W-1:0]  ram_ahi,
  input logic              rd_n,
  input logic              wr_n,
  input logic [BANK_W-1:0] bank_q,
  input rgn_e              rgn_w
);
  AST_WIN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi < 4'h4) |-> (!ram_cs_n && ram_ahi == bank_q[SEL_W-1:0])); // R1

  AST_FIXED_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi >= 4'h4 && addr_hi <= 4'h9) |->
      (!ram_cs_n && ram_ahi == {1'b0, addr_hi[3:2]})); // R2

  AST_DEV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (rgn_w == RGN_DEV) |-> (!dev_cs_n && ram_cs_n && rom_cs_n)); // R3

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ram_cs_n, ~rom_cs_n, ~dev_cs_n}) <= 1); // R3

  AST_TOP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi >= 4'hB) |-> (rom_en ? (!rom_cs_n && ram_cs_n)
                                  : (!ram_cs_n && rom_cs_n &&
                                     ram_ahi == {1'b0, addr_hi[3:2]}))); // R4

  AST_RESET_BANK: assert property (@(posedge clk)
    $rose(rst_n) |-> (bank_q == '0)); // R5

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ld |=> (bank_q == $past(bank_d))); // R6

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ld |=> $stable(bank_q)); // R6

  AST_STRB_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n) == (cpu_e && cpu_rw)); // R8

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n) && ((!wr_n) == (cpu_e && !cpu_rw))); // R8
endmodule

bind bmm_mapper bmm_mapper_chk chk_i (.*);

// File: tb/bmm_mapper_tb.sv
module bmm_mapper_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr_hi = 4'h0;
  logic       cpu_rw = 1'b1;
  logic       cpu_e = 1'b0;
  logic [3:0] bank_d = 4'h0;
  logic       bank_ld = 1'b0;
  logic       rom_en = 1'b1;
  logic       ram_cs_n, rom_cs_n, dev_cs_n, rd_n, wr_n;
  logic [2:0] ram_ahi;
  logic [3:0] bank_q;

  logic [13:0] lo_addr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  mbank = '0;
  byte unsigned mem [int];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bmm_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .cpu_rw(cpu_rw), .cpu_e(cpu_e),
    .bank_d(bank_d), .bank_ld(bank_ld), .rom_en(rom_en),
    .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .dev_cs_n(dev_cs_n),
    .ram_ahi(ram_ahi), .rd_n(rd_n), .wr_n(wr_n), .bank_q(bank_q)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic int mem_at(input int key);
    if (mem.exists(key)) return int'(mem[key]);
    return 0;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // reference model compared every clock
  task automatic compare();
    int a;
    string tag;
    int exp_sel;  // {ram_cs_n, rom_cs_n, dev_cs_n}
    int exp_hi;
    a = int'(addr_hi) * 4096;
    exp_hi = -1;
    if (a < 16384) begin
      tag = "R1"; exp_sel = 3'b011; exp_hi = int'(mbank) % 8;
    end else if (a < 40960) begin
      tag = "R2"; exp_sel = 3'b011; exp_hi = a / 16384;
    end else if (a < 45056) begin
      tag = "R3"; exp_sel = 3'b110;
    end else if (rom_en) begin
      tag = "R4"; exp_sel = 3'b101;
    end else begin
      tag = "R4"; exp_sel = 3'b011; exp_hi = a / 16384;
    end
    check(tag, "selects", int'({ram_cs_n, rom_cs_n, dev_cs_n}), exp_sel);
    if (exp_hi >= 0) check(tag, "ram_ahi", int'(ram_ahi), exp_hi);
    check("R8", "rd_n", int'(rd_n), (cpu_e && cpu_rw) ? 0 : 1);
    check("R8", "wr_n", int'(wr_n), (cpu_e && !cpu_rw) ? 0 : 1);
    check("R6", "bank_q", int'(bank_q), int'(mbank));
  endtask

  always @(posedge clk) begin
    if (!rst_n) mbank = 4'h0;
    else if (bank_ld) mbank = bank_d;
    if (rst_n && !ram_cs_n && !wr_n) mem[int'({ram_ahi, lo_addr})] = wdata;
    #2;
    if (rst_n && !done) compare();
  end

  task automatic cyc(input logic [15:0] a, input logic rw, input logic e,
                     input logic ld, input logic [7:0] d, input logic re);
    @(negedge clk);
    addr_hi = a[15:12];
    lo_addr = a[13:0];
    cpu_rw  = rw;
    cpu_e   = e;
    bank_ld = ld;
    bank_d  = d[3:0];
    wdata   = d;
    rom_en  = re;
  endtask

  task automatic settle();
    @(posedge clk);
    #3;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R5", "bank after reset", int'(bank_q), 0);
    check("R5", "window hi after reset", int'(ram_ahi), 0);

    // region sweep, both modes, reads and idle phase
    for (int m = 0; m < 2; m++)
      for (int n = 0; n < 16; n++)
        cyc(16'(n * 4096), 1'b1, 1'b1, 1'b0, 8'h00, m == 0);

    // bank load
    cyc(16'hA003, 1'b0, 1'b1, 1'b1, 8'h05, 1'b1);
    cyc(16'h1234, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1);
    settle();
    check("R6", "window after load 5", int'(ram_ahi), 5);

    // no strobe: bank holds despite new data
    cyc(16'h1234, 1'b1, 1'b1, 1'b0, 8'h07, 1'b1);
    settle();
    check("R6", "hold without strobe", int'(bank_q), 5);

    // bit 3 stored but ignored
    cyc(16'hA000, 1'b0, 1'b1, 1'b1, 8'h0D, 1'b1);
    cyc(16'h0000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1);
    settle();
    check("R7", "bank_q keeps bit 3", int'(bank_q), 13);
    check("R7", "ram_ahi ignores bit 3", int'(ram_ahi), 5);

    // bank 2 aliasing, window write seen in fixed RAM
    cyc(16'hA000, 1'b0, 1'b1, 1'b1, 8'h02, 1'b1);
    cyc(16'h0123, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b1);
    cyc(16'h8123, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1);
    settle();
    check("R9", "fixed RAM corrupted via window", mem_at(int'({ram_ahi, lo_addr})), 8'h5A);
    // fixed write seen through window
    cyc(16'h9FFE, 1'b0, 1'b1, 1'b0, 8'hC3, 1'b1);
    cyc(16'h1FFE, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1);
    settle();
    check("R9", "window sees fixed write", mem_at(int'({ram_ahi, lo_addr})), 8'hC3);

    // RAM-only mode write, then ROM mode write must not reach RAM
    cyc(16'hC010, 1'b0, 1'b1, 1'b0, 8'hE7, 1'b0);
    cyc(16'hC010, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    settle();
    check("R4", "RAM-only top write", mem_at(int'({ram_ahi, lo_addr})), 8'hE7);
    cyc(16'hC010, 1'b0, 1'b1, 1'b0, 8'h11, 1'b1);
    cyc(16'hC010, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    settle();
    check("R4", "ROM-mode write ignored by RAM", mem_at(int'({ram_ahi, lo_addr})), 8'hE7);

    // strobe phases
    cyc(16'h5000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    cyc(16'h5000, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1);
    cyc(16'h5000, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
    settle();
    check("R8", "write strobe low", int'(wr_n), 0);
    check("R8", "read strobe high on write", int'(rd_n), 1);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule